// File: doc/BRIEF.md
# Range-Selected Watchdog Timer

A watchdog timer on a simple 32-bit register bus. Software picks one of sixteen timeout lengths with a small range index. Each index doubles the previous timeout: the reload is an all-ones value whose width starts at a parameterised minimum and grows by one bit per index step. The width is capped one bit short of the counter width. Software restarts the countdown by writing a fixed key to a restart register. Writes of any other value do nothing.

Once enabled, the counter counts down by one per clock. A timeout occurs on the clock at which the counter is already zero. In direct mode that timeout asks for a system reset at once. In interrupt-first mode, the first timeout raises an interrupt and reloads the counter. A second timeout, while the interrupt is still pending, then asks for the reset. The reset request is a pulse of fixed length. After it, the watchdog stays expired until the system reset arrives.

Top module: `pow2_watchdog`

## Requirements
- R1: The reload value for range index i is 2^(MIN_BITS+i)-1, capped at 2^(CNT_W-1)-1. With MIN_BITS=16 and CNT_W=32, range 0 gives 0xFFFF and range 15 gives 0x7FFFFFFF.
- R2: The range register sits at offset 0x04, with the index in bits [3:0]. A write to it takes effect only while the enable bit is clear; while enabled, the write is ignored.
- R3: Writing exactly 0x00000076 to offset 0x0C reloads the counter from the selected range. Any other value written there leaves the counter untouched.
- R4: The control register sits at offset 0x00, with bit0 = enable and bit1 = interrupt-first mode. After reset, control, range and interrupt status are zero, and the counter holds the range-0 reload.
- R5: While enabled and not expired, the counter (read at offset 0x08) drops by one each clock. While disabled, it holds its value. A timeout occurs on a clock where the counter is zero.
- R6: With bit1 clear, a timeout raises the reset request, and the interrupt stays low.
- R7: With bit1 set, a timeout while the interrupt status is clear sets that status and reloads the counter. The status is output irq and reads as bit0 of offset 0x10. A timeout while the status is set raises the reset request.
- R8: A read of offset 0x14 returns zero and clears the interrupt status. A timeout that sets the status in the same cycle wins over the clear.
- R9: The reset request goes high the clock after the timeout and stays high for exactly 16 clocks. After that the watchdog is expired: the counter stops, restart writes are ignored and no further pulse occurs until rstN.
- R10: Read data appears on busRdata the clock after busRd. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irq | output | 1 | Pending interrupt in interrupt-first mode |
| sysRstReq | output | 1 | System reset request pulse |

## Verification
A counter that decrements wrongly or reloads from the wrong range is seen first at the count offset. It reaches irq or sysRstReq exactly one timeout period late or early. A lost or stuck interrupt status changes whether the second timeout bites, so it shows up as a missing or extra reset pulse within two periods. The bench compares irq and sysRstReq against a behavioural model on every clock, so any such slip shows on the very cycle it first reaches a port.

// File: rtl/pow2_watchdog_pkg.sv
package pow2_watchdog_pkg;
  localparam logic [31:0] RESTART_KEY = 32'h0000_0076;
  localparam logic [7:0]  OFF_CTRL  = 8'h00;
  localparam logic [7:0]  OFF_RANGE = 8'h04;
  localparam logic [7:0]  OFF_COUNT = 8'h08;
  localparam logic [7:0]  OFF_KICK  = 8'h0C;
  localparam logic [7:0]  OFF_STAT  = 8'h10;
  localparam logic [7:0]  OFF_EOI   = 8'h14;

  typedef struct packed {
    logic rangeWe;  // latch a new range index
    logic reload;   // load counter from range table
    logic dec;      // count down by one
  } dpStrobe_t;
endpackage

// File: rtl/pow2_watchdog_dp.sv
module pow2_watchdog_dp
  import pow2_watchdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int MIN_BITS = 16,
  parameter int RANGE_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [RANGE_W-1:0] rangeIn,
  output logic [CNT_W-1:0]   countVal,
  output logic [RANGE_W-1:0] rangeVal,
  output logic               atZero
);
  localparam int RANGE_N  = 1 << RANGE_W;
  localparam int MAX_BITS = CNT_W - 1;
  localparam int BITS0    = (MIN_BITS > MAX_BITS) ? MAX_BITS : MIN_BITS;
  localparam logic [CNT_W-1:0] RESET_CNT = {{(CNT_W-BITS0){1'b0}}, {BITS0{1'b1}}};

  logic [CNT_W-1:0] reloadTbl [RANGE_N];

  for (genvar i = 0; i < RANGE_N; i++) begin : g_tbl
    localparam int B = (MIN_BITS + i > MAX_BITS) ? MAX_BITS : MIN_BITS + i;
    assign reloadTbl[i] = {{(CNT_W-B){1'b0}}, {B{1'b1}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeVal <= '0;
      countVal <= RESET_CNT;
    end else begin
      if (stb.rangeWe) rangeVal <= rangeIn;
      if (stb.reload)   countVal <= reloadTbl[rangeVal];
      else if (stb.dec) countVal <= countVal - 1'b1;
    end
  end

  assign atZero = (countVal == '0);
endmodule

// File: rtl/pow2_watchdog_ctrl.sv
module pow2_watchdog_ctrl
  import pow2_watchdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RANGE_W   = 4,
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  input  logic [CNT_W-1:0]   countVal,
  input  logic [RANGE_W-1:0] rangeVal,
  input  logic               atZero,
  output dpStrobe_t          stb,
  output logic [31:0]        busRdata,
  output logic               enBit,
  output logic               modeBit,
  output logic               intStat,
  output logic               expired,
  output logic               sysRstReq
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic [PC_W-1:0] pulseCnt;
  logic hitCtrl, hitRange, hitKick, hitEoi;
  logic kick, active, expire, bark, bite;

  assign hitCtrl  = busAddr == ADDR_W'(OFF_CTRL);
  assign hitRange = busAddr == ADDR_W'(OFF_RANGE);
  assign hitKick  = busAddr == ADDR_W'(OFF_KICK);
  assign hitEoi   = busAddr == ADDR_W'(OFF_EOI);

  assign kick   = busWr && hitKick && (busWdata == RESTART_KEY) && !expired;
  assign active = enBit && !expired;
  assign expire = active && atZero && !kick;
  assign bark   = expire && modeBit && !intStat;
  assign bite   = expire && !bark;

  always_comb begin
    stb.rangeWe = busWr && hitRange && !enBit;
    stb.reload  = kick || bark;
    stb.dec     = active && !atZero && !kick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      modeBit  <= 1'b0;
      intStat  <= 1'b0;
      expired  <= 1'b0;
      pulseCnt <= '0;
      busRdata <= '0;
    end else begin
      if (busWr && hitCtrl) begin
        enBit   <= busWdata[0];
        modeBit <= busWdata[1];
      end
      if (bark)                  intStat <= 1'b1;
      else if (busRd && hitEoi)  intStat <= 1'b0;
      if (bite) begin
        expired  <= 1'b1;
        pulseCnt <= PC_W'(PULSE_LEN);
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
      if (busRd) begin
        unique case (busAddr)
          ADDR_W'(OFF_CTRL):  busRdata <= {30'd0, modeBit, enBit};
          ADDR_W'(OFF_RANGE): busRdata <= 32'(rangeVal);
          ADDR_W'(OFF_COUNT): busRdata <= 32'(countVal);
          ADDR_W'(OFF_STAT):  busRdata <= {31'd0, intStat};
          default:            busRdata <= '0;
        endcase
      end
    end
  end

  assign sysRstReq = pulseCnt != '0;
endmodule

// File: rtl/pow2_watchdog.sv
module pow2_watchdog
  import pow2_watchdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int MIN_BITS  = 16,
  parameter int RANGE_W   = 4,
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              sysRstReq
);
  dpStrobe_t          stb;
  logic [CNT_W-1:0]   countVal;
  logic [RANGE_W-1:0] rangeVal;
  logic               atZero, enBit, modeBit, intStat, expired;

  pow2_watchdog_dp #(.CNT_W(CNT_W), .MIN_BITS(MIN_BITS), .RANGE_W(RANGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rangeIn(busWdata[RANGE_W-1:0]),
    .countVal(countVal), .rangeVal(rangeVal), .atZero(atZero)
  );

  pow2_watchdog_ctrl #(.CNT_W(CNT_W), .RANGE_W(RANGE_W), .ADDR_W(ADDR_W),
                       .PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .countVal(countVal), .rangeVal(rangeVal), .atZero(atZero),
    .stb(stb), .busRdata(busRdata), .enBit(enBit), .modeBit(modeBit),
    .intStat(intStat), .expired(expired), .sysRstReq(sysRstReq)
  );

  assign irq = intStat;
endmodule

// File: rtl/pow2_watchdog_chk.sv
module pow2_watchdog_chk
  import pow2_watchdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input dpStrobe_t        stb,
  input logic [CNT_W-1:0] countVal,
  input logic             atZero,
  input logic             enBit,
  input logic             modeBit,
  input logic             intStat,
  input logic             expired,
  input logic             sysRstReq
);
  localparam logic [CNT_W-1:0] CAP = {1'b0, {(CNT_W-1){1'b1}}};

  a_r1_cap: assert property (@(posedge clk) disable iff (!rstN) countVal <= CAP);

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !expired && !atZero && !stb.reload) |=> countVal == $past(countVal) - 1'b1);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !stb.reload) |=> $stable(countVal));

  a_r9_bite_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstReq) |-> $past(enBit && atZero && !expired));

  a_r7_second_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sysRstReq) && $past(modeBit)) |-> $past(intStat));

  a_r9_expired_holds: assert property (@(posedge clk) disable iff (!rstN)
    expired |=> expired);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstReq) |=> !sysRstReq);
endmodule

bind pow2_watchdog pow2_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .countVal(countVal), .atZero(atZero),
  .enBit(enBit), .modeBit(modeBit), .intStat(intStat), .expired(expired),
  .sysRstReq(sysRstReq)
);

// File: tb/pow2_watchdog_tb.sv
module pow2_watchdog_tb;
  localparam int MIN_BITS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq, sysRstReq;

  logic bRd = 1'b0, bWr = 1'b0;
  logic [7:0] bAddr = '0;
  logic [31:0] bWdata = '0;
  logic [31:0] bRdata;
  logic bIrq, bRst;

  int vectors = 0, errors = 0, cycles = 0;
  string curTag = "R10";
  bit done = 1'b0;

  always #10 clk = ~clk;

  pow2_watchdog #(.MIN_BITS(MIN_BITS)) u_dut (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sysRstReq(sysRstReq));

  pow2_watchdog u_big (
    .clk(clk), .rstN(rstN), .busRd(bRd), .busWr(bWr), .busAddr(bAddr),
    .busWdata(bWdata), .busRdata(bRdata), .irq(bIrq), .sysRstReq(bRst));

  // behavioural reference model
  longint mCnt; int mRange, mInt, mExp, mPulse; bit mEn, mMode;
  bit mRdValid; longint mRd;

  function automatic longint reloadOf(int idx, int minBits, int cntW);
    longint r = (longint'(1) << (minBits + idx)) - 1;
    longint cap = (longint'(1) << (cntW - 1)) - 1;
    return (r > cap) ? cap : r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = reloadOf(0, MIN_BITS, 32); mRange = 0; mInt = 0; mExp = 0;
      mPulse = 0; mEn = 0; mMode = 0; mRdValid = 0; mRd = 0;
    end else begin
      bit kick, act, exp, bark, bite;
      longint rdNew;
      kick = busWr && busAddr == 8'h0C && busWdata == 32'h76 && mExp == 0;
      act  = mEn && mExp == 0;
      exp  = act && mCnt == 0 && !kick;
      bark = exp && mMode && mInt == 0;
      bite = exp && !bark;
      case (busAddr)
        8'h00: rdNew = {mMode, mEn};
        8'h04: rdNew = mRange;
        8'h08: rdNew = mCnt;
        8'h10: rdNew = mInt;
        default: rdNew = 0;
      endcase
      mRdValid = busRd;
      if (busRd) mRd = rdNew;
      if (kick || bark) mCnt = reloadOf(mRange, MIN_BITS, 32);
      else if (act && mCnt != 0) mCnt = mCnt - 1;
      if (busWr && busAddr == 8'h04 && !mEn) mRange = busWdata & 32'hF;
      if (bark) mInt = 1;
      else if (busRd && busAddr == 8'h14) mInt = 0;
      if (bite) begin mExp = 1; mPulse = 16; end
      else if (mPulse > 0) mPulse = mPulse - 1;
      if (busWr && busAddr == 8'h00) begin mEn = busWdata[0]; mMode = busWdata[1]; end
    end
  end

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every clock, away from the edges
  always @(posedge clk) begin
    cycles++;
    #5;
    if (rstN && !done) begin
      check("R7 irq", irq, mInt);
      check(mMode ? "R9 sysRstReq" : "R6 sysRstReq", sysRstReq, mPulse > 0);
      if (mRdValid) check(curTag, busRdata, mRd);
    end
  end

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, string tag);
    @(negedge clk); busRd = 1'b1; busAddr = a; curTag = tag;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    idle(2); rstN = 1'b1;
  endtask

  task automatic bigRange(int idx, longint exp);
    @(negedge clk); bWr = 1'b1; bAddr = 8'h04; bWdata = idx;
    @(negedge clk); bAddr = 8'h0C; bWdata = 32'h76;
    @(negedge clk); bWr = 1'b0; bRd = 1'b1; bAddr = 8'h08;
    @(negedge clk); bRd = 1'b0;
    @(posedge clk); #5;
    check("R1 wide reload", bRdata, exp);
  endtask

  initial begin
    int w = 0;
    while (!done && w < 150000) begin @(posedge clk); w++; end
    if (!done) begin
      done = 1'b1; errors++; vectors++;
      $display("FAIL watchdog expired, run hung");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rstN = 1'b1;
    // R4 reset state, R1 range-0 reload
    rdReg(8'h00, "R4 ctrl reset"); rdReg(8'h04, "R4 range reset");
    rdReg(8'h08, "R1 reset count"); rdReg(8'h10, "R4 status reset");
    rdReg(8'h1C, "R10 unmapped");
    // R2 range write while disabled, R3 key restart
    wrReg(8'h04, 32'h2); rdReg(8'h04, "R2 range accepted");
    wrReg(8'h0C, 32'h76); rdReg(8'h08, "R3 restart reload R1");
    wrReg(8'h0C, 32'h55); rdReg(8'h08, "R3 bad key ignored");
    // interrupt-first mode, R2 range ignored while enabled
    wrReg(8'h00, 32'h3); wrReg(8'h04, 32'h5);
    rdReg(8'h04, "R2 range ignored"); rdReg(8'h08, "R5 counting");
    // kicking keeps it alive
    for (int k = 0; k < 4; k++) begin idle(40); wrReg(8'h0C, 32'h76); end
    rdReg(8'h10, "R3 kicks prevent status");
    // disable freezes count
    wrReg(8'h00, 32'h2); rdReg(8'h08, "R5 frozen a"); idle(5);
    rdReg(8'h08, "R5 frozen b");
    wrReg(8'h00, 32'h3);
    idle(80); rdReg(8'h10, "R7 first timeout status");
    rdReg(8'h14, "R8 eoi read"); rdReg(8'h10, "R8 status cleared");
    idle(70); rdReg(8'h08, "R7 reloaded count");
    idle(80);                 // second timeout with status set bites
    rdReg(8'h08, "R9 counter stopped");
    wrReg(8'h0C, 32'h76); rdReg(8'h08, "R9 restart ignored");
    idle(40);
    // direct mode
    doReset();
    wrReg(8'h00, 32'h1); idle(30);
    rdReg(8'h10, "R6 no status in direct mode");
    idle(30);
    bigRange(0, 64'hFFFF);
    bigRange(15, 64'h7FFFFFFF);
    bigRange(3, 64'h7FFFF);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule